// File: doc/BRIEF.md
# Random Interval Pulse Timer

The block emits a single-cycle pulse at pseudo-random intervals. A 128-bit xorshift generator, kept as four 32-bit words, supplies one fresh word per interval. The low bits of that word, offset by a fixed base, give the number of prescaler ticks the next interval lasts. A down-counter consumes those ticks. When the last tick of an interval is taken, the block pulses, advances the generator once and reloads the counter, all on the same edge, so intervals follow one another with no gap.

The prescaler is outside the block and reaches it as a tick enable. Only the low word of the generator is brought out, so a reference model can follow the sequence. The full 128-bit state is still kept, because the recurrence needs all of it. With the defaults, intervals span 1000 to 9191 ticks.

Top module: `rand_interval_timer`

## Requirements
- R1: While reset is asserted, pulse_o is 0 and rand_o equals the seed low word, which is 1 by default. The other three state words reset to 0.
- R2: On the first clock edge after reset is released, the generator advances once and the counter loads the interval taken from that new word. No pulse is produced on that edge, whatever the tick input is.
- R3: Each advance shifts the three lower words up one position and places a new low word at bits 31:0. With x the top word (bits 127:96), w the old low word and t = x ^ (x << 11), the new low word is w ^ (w >> 19) ^ t ^ (t >> 8). All shifts are logical. rand_o always shows the low word.
- R4: Each interval length, counted in ticks, is RELOAD_BASE plus the low RAND_BITS bits of the word that produced it. The defaults are 1000 and 13. RELOAD_BASE must be at least 2.
- R5: The counter moves only on cycles where tick_i is 1. With tick_i held at 0, no pulse occurs and rand_o holds its value.
- R6: pulse_o is 1 for exactly one cycle, in the cycle that follows the edge at which the last tick of the interval is taken. At that same edge rand_o changes to the next generator word, and the next interval begins.
- R7: The 128-bit generator state is never all zero while out of reset.
- R8: Asserting reset in the middle of a run restarts the sequence from the seed. The run after release repeats the first run's words and intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick enable |
| pulse_o | output | 1 | One-cycle expiry pulse |
| rand_o | output | 32 | Current low generator word |

## Verification
The bench builds the timer with RELOAD_BASE = 20 and RAND_BITS = 5, so intervals last 20 to 51 ticks. This brings hundreds of intervals, and the generator's move out of its sparse seeded start into well-mixed words, within a short run. The bench drives tick patterns that are always on, absent, about half dense and sparse. A scoreboard checks each word and each interval length against an independent model of the recurrence. A reset in the middle of the run confirms that the sequence restarts from the seed.

// File: rtl/rit_pkg.sv
`timescale 1ns/1ps
package rit_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned NUM_WORDS = 4;
  localparam int unsigned STATE_W  = WORD_W * NUM_WORDS;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [STATE_W-1:0] state_t;

  // xorshift step: w' = w ^ w>>b ^ t ^ t>>c, t = x ^ x<<a
  function automatic word_t xs_mix(word_t x, word_t w, int unsigned sa, int unsigned sb,
                                   int unsigned sc);
    word_t t;
    t = x ^ (x << sa);
    return w ^ (w >> sb) ^ t ^ (t >> sc);
  endfunction
endpackage

// File: rtl/xorshift128_core.sv
`timescale 1ns/1ps
module xorshift128_core
  import rit_pkg::*;
#(
  parameter int unsigned SHL_A   = 11,
  parameter int unsigned SHR_B   = 19,
  parameter int unsigned SHR_C   = 8,
  parameter word_t       SEED_LO = 32'd1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   adv_i,
  output word_t  word_o,
  output word_t  next_word_o,
  output state_t state_o
);
  state_t state_q;
  word_t  words [NUM_WORDS];
  word_t  nw;

  // word view of the packed state, word 0 is the low word
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_words
    assign words[i] = state_q[i*WORD_W +: WORD_W];
  end

  assign nw = xs_mix(words[NUM_WORDS-1], words[0], SHL_A, SHR_B, SHR_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= {{(STATE_W-WORD_W){1'b0}}, SEED_LO};
    end else if (adv_i) begin
      state_q <= {state_q[STATE_W-WORD_W-1:0], nw};
    end
  end

  assign word_o      = words[0];
  assign next_word_o = nw;
  assign state_o     = state_q;
endmodule

// File: rtl/reload_map.sv
`timescale 1ns/1ps
module reload_map
  import rit_pkg::*;
#(
  parameter int unsigned RELOAD_BASE = 1000,
  parameter int unsigned RAND_BITS   = 13,
  parameter int unsigned CNT_W       = 14
) (
  input  word_t            word_i,
  output logic [CNT_W-1:0] load_o
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(RELOAD_BASE);

  logic [CNT_W-1:0] span;

  if (CNT_W > RAND_BITS) begin : g_pad
    assign span = {{(CNT_W-RAND_BITS){1'b0}}, word_i[RAND_BITS-1:0]};
  end else begin : g_nopad
    assign span = word_i[CNT_W-1:0];
  end

  assign load_o = span + BASE_V;
endmodule

// File: rtl/interval_counter.sv
`timescale 1ns/1ps
module interval_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             adv_o,
  output logic             fire_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fire;
  logic             adv;

  assign fire = armed_q & tick_i & (cnt_q == ONE);
  assign adv  = fire | ~armed_q;  // first edge after reset arms

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= 1'b1;
      if (adv)         cnt_q <= load_i;
      else if (tick_i) cnt_q <= cnt_q - ONE;
    end
  end

  assign adv_o   = adv;
  assign fire_o  = fire;
  assign armed_o = armed_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rand_interval_timer.sv
`timescale 1ns/1ps
module rand_interval_timer
  import rit_pkg::*;
#(
  parameter int unsigned RELOAD_BASE = 1000,
  parameter int unsigned RAND_BITS   = 13,
  parameter int unsigned SHL_A       = 11,
  parameter int unsigned SHR_B       = 19,
  parameter int unsigned SHR_C       = 8,
  localparam int unsigned CNT_W      = $clog2(RELOAD_BASE + (1 << RAND_BITS))
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  output logic        pulse_o,
  output logic [31:0] rand_o
);
  word_t            next_word;
  state_t           state_q;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt_q;
  logic             adv;
  logic             fire;
  logic             armed_q;
  logic             pulse_q;

  xorshift128_core #(
    .SHL_A  (SHL_A),
    .SHR_B  (SHR_B),
    .SHR_C  (SHR_C),
    .SEED_LO(32'd1)
  ) gen_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .word_o     (rand_o),
    .next_word_o(next_word),
    .state_o    (state_q)
  );

  reload_map #(
    .RELOAD_BASE(RELOAD_BASE),
    .RAND_BITS  (RAND_BITS),
    .CNT_W      (CNT_W)
  ) map_i (
    .word_i(next_word),
    .load_o(load_val)
  );

  interval_counter #(
    .CNT_W(CNT_W)
  ) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .load_i (load_val),
    .adv_o  (adv),
    .fire_o (fire),
    .armed_o(armed_q),
    .cnt_o  (cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rit_chk.sv
`timescale 1ns/1ps
module rit_chk #(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned RELOAD_BASE = 1000,
  parameter int unsigned RAND_BITS   = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             pulse_o,
  input logic [31:0]      rand_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic             armed_q,
  input logic [127:0]     state_q
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(RELOAD_BASE);
  localparam logic [CNT_W-1:0] HI = CNT_W'(RELOAD_BASE + (1 << RAND_BITS) - 1);

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R6
  pulse_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick_i));

  // R4
  reload_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && armed_q) |-> (cnt_q >= LO && cnt_q <= HI));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(armed_q) && !$past(tick_i) && !pulse_o) |-> ($stable(cnt_q) && $stable(rand_o)));

  // R7
  state_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  // R2
  arm_no_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !$past(armed_q)) |-> !pulse_o);
endmodule

bind rand_interval_timer rit_chk #(
  .CNT_W      (CNT_W),
  .RELOAD_BASE(RELOAD_BASE),
  .RAND_BITS  (RAND_BITS)
) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .pulse_o(pulse_o),
  .rand_o (rand_o),
  .cnt_q  (cnt_q),
  .armed_q(armed_q),
  .state_q(state_q)
);

// File: tb/rand_interval_timer_tb_top.sv
`timescale 1ns/1ps
module rand_interval_timer_tb_top;
  localparam int BASE  = 20;
  localparam int RBITS = 5;

  typedef struct {
    int          len;
    logic [31:0] word;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        pulse_o;
  logic [31:0] rand_o;

  int   checks = 0;
  int   bad = 0;
  exp_t q[$];
  logic [127:0] mdl_s;
  int   cur_len;
  bit   mon_on = 1'b0;
  bit   prev_tick = 1'b0;
  int   ticks_seen = 0;
  int   pulses = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rand_interval_timer #(
    .RELOAD_BASE(BASE),
    .RAND_BITS  (RBITS)
  ) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pulse_o(pulse_o),
    .rand_o (rand_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference recurrence
  function automatic logic [31:0] mdl_step();
    logic [31:0] x, w, t, nw;
    x  = mdl_s[127:96];
    w  = mdl_s[31:0];
    t  = x ^ (x << 11);
    nw = w ^ (w >> 19) ^ t ^ (t >> 8);
    mdl_s = {mdl_s[95:0], nw};
    return nw;
  endfunction

  // returns the first word after reset and primes the model
  function automatic logic [31:0] mdl_reset();
    logic [31:0] w1;
    mdl_s   = 128'd1;
    w1      = mdl_step();
    cur_len = BASE + int'(w1[RBITS-1:0]);
    return w1;
  endfunction

  // driver side: push expected items
  task automatic push_expected(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = mdl_step();
      q.push_back('{len: cur_len, word: w});
      cur_len = BASE + int'(w[RBITS-1:0]);
    end
  endtask

  // monitor: ticks taken at the last edge, then any pulse from it
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_tick) ticks_seen++;
      if (pulse_o) begin
        pulses++;
        if (q.size() == 0) begin
          checks++; bad++;
          $display("FAIL R6: actual=pulse expected=no pending item");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R6/R4 interval", 32'(ticks_seen), 32'(e.len));
          chk("R3 word", rand_o, e.word);
        end
        ticks_seen = 0;
      end
      prev_tick = tick_i;
    end else begin
      prev_tick  = 1'b0;
      ticks_seen = 0;
    end
  end

  // mode: 0 none, 1 always, 2 about half, 3 one in four
  task automatic drive(input int mode, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      case (mode)
        0:       tick_i = 1'b0;
        1:       tick_i = 1'b1;
        2:       tick_i = ($urandom % 2) == 0;
        default: tick_i = ($urandom % 4) == 0;
      endcase
    end
  endtask

  task automatic reset_and_arm(input string tag);
    logic [31:0] w1;
    @(posedge clk); #1;
    mon_on = 1'b0; tick_i = 1'b0; rst_ni = 1'b0;
    q.delete();
    repeat (3) @(posedge clk);
    #2;
    chk({tag, " R1 pulse"}, 32'(pulse_o), 32'd0);
    chk({tag, " R1 rand"}, rand_o, 32'd1);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    tick_i = 1'b1;  // a tick on the arming edge must not count
    @(posedge clk); #1;
    tick_i = 1'b0;
    #1;
    w1 = mdl_reset();
    chk({tag, " R2 first word"}, rand_o, w1);
    chk({tag, " R2 no pulse"}, 32'(pulse_o), 32'd0);
    push_expected(600);
    mon_on = 1'b1;
  endtask

  initial begin : main
    int p0;
    logic [31:0] r0;
    reset_and_arm("run1");

    // R5: no ticks, nothing moves
    r0 = rand_o; p0 = pulses;
    drive(0, 300);
    #2;
    chk("R5 no pulse", 32'(pulses - p0), 32'd0);
    chk("R5 rand held", rand_o, r0);

    p0 = pulses;
    drive(1, 2000);
    checks++; if (pulses - p0 < 30) begin bad++; $display("FAIL R6: actual=%0d expected>=30 pulses", pulses - p0); end
    drive(2, 3000);
    drive(3, 4000);
    drive(1, 500);

    // R8: restart mid-interval
    reset_and_arm("run2");
    p0 = pulses;
    drive(1, 1500);
    drive(3, 2000);
    checks++; if (pulses - p0 < 20) begin bad++; $display("FAIL R8: actual=%0d expected>=20 pulses", pulses - p0); end
    drive(0, 10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule